// File: doc/BRIEF.md
# PCI Target Read Lane Sequencer

This block is the read-side control of a PCI target that sits on a 32-bit bus while its back-end memory delivers 64-bit words. It watches the bus frame, initiator ready and command/byte-enable lines and latches the address and command at the start of a transaction. It checks the address against a single memory window and, on a read that falls inside the window, raises a hit line that the back-end can use as a chip select. It then drives device select and target ready and serves single or burst reads one DWORD at a time.

The local side works as a stream. The back-end holds its current 64-bit word on `lcl_data`. It marks that it can serve a beat by pulling `lcl_rdy_n` low, which acts as valid. The block accepts a beat with a one-cycle strobe, `lo_xfer_n` for the lower DWORD or `hi_xfer_n` for the upper DWORD; the strobe acts as ready. Back-pressure runs both ways. While local ready is high no strobe is issued and the bus data phase waits with target ready high. While initiator ready is high no strobe is issued either. The back-end keeps the same word until it sees an upper-half strobe, then steps to the next word. An odd-DWORD start address begins on the upper half, and the lower DWORD of that first word never reaches the bus.

Bus outputs are active low. Enables (`ad_oe`, `ctl_oe`) tell the pad ring when to drive AD and the device-select/target-ready pair.

Top module: `pci_rd_lane_seq`

## Requirements
- R1: When `frame_n` is sampled low while idle, `ad_in` and `cbe_n` are latched on that edge, and `lcl_addr` shows the latched address from the next cycle on.
- R2: If the latched address lies in the window (bits above `BAR_LOG2` equal `BAR_BASE`) and the command is a memory read (`cbe_n` = 4'b0110, 4'b1100 or 4'b1110), `bar_hit` rises one edge after the address is latched and stays high until the completion in R8.
- R3: A transaction outside the window, or one with any other command, is ignored. `bar_hit`, `devsel_n`, `trdy_n`, `ad_oe` and `ctl_oe` stay inactive, and the block waits for `frame_n` and `irdy_n` both high before it looks for a new address.
- R4: `devsel_n` goes low exactly one clock after `bar_hit` rises (slow decode), with `ctl_oe` high.
- R5: With address bit 2 = 0, the first strobe is `lo_xfer_n` and its data phase carries `lcl_data[31:0]`. Strobes then alternate, each upper one carrying `lcl_data[63:32]`, so AD carries consecutive DWORDs from the start address.
- R6: With address bit 2 = 1, the first strobe is `hi_xfer_n` and its data phase carries `lcl_data[63:32]`. The lower DWORD of that word never appears on AD, and the alternation of R5 follows.
- R7: A strobe is issued only if `irdy_n` and `lcl_rdy_n` were both low in the previous cycle. Exactly one strobe is issued per data phase, and `trdy_n` is low in the cycle right after it, with the strobed half on `ad_out`.
- R8: When a data phase completes (`irdy_n` and `trdy_n` low) with `frame_n` high, the next cycle has `trdy_n` and `devsel_n` high, `ad_oe` low and `ctl_oe` still high. The cycle after that has `ctl_oe` and `bar_hit` low, and the block is idle.
- R9: `ad_oe` is low in the cycle after the address phase and is high whenever `trdy_n` is low.
- R10: After reset, `devsel_n`, `trdy_n`, `lo_xfer_n` and `hi_xfer_n` are high and `ad_oe`, `ctl_oe` and `bar_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Transaction frame from initiator |
| irdy_n | input | 1 | Initiator ready |
| cbe_n | input | 4 | Command in address phase, byte enables after |
| ad_in | input | 32 | Address/data bus as received |
| ad_out | output | 32 | Read data driven to the bus |
| ad_oe | output | 1 | Drive enable for AD |
| devsel_n | output | 1 | Device select |
| trdy_n | output | 1 | Target ready |
| ctl_oe | output | 1 | Drive enable for devsel_n and trdy_n |
| bar_hit | output | 1 | Window hit, back-end chip select |
| lcl_addr | output | 32 | Latched transaction address |
| lcl_rdy_n | input | 1 | Back-end can serve the next beat (valid) |
| lo_xfer_n | output | 1 | Lower-DWORD accept strobe |
| hi_xfer_n | output | 1 | Upper-DWORD accept strobe |
| lcl_data | input | 64 | Current back-end word |

## Verification
If the address edge is cycle 0, `bar_hit` is due in cycle 1 and `devsel_n` in cycle 2. With both ready lines low, the first strobe follows in cycle 3 and `trdy_n` in cycle 4. After the final completing phase, release is due one cycle later and `bar_hit`/`ctl_oe` drop two cycles later. The bench drives and samples on falling edges and numbers each sample from the address edge. It compares every timed result against that exact sample index, checks `trdy_n` in the sample right after each strobe, and compares each completed phase's AD value against a DWORD computed from the start address and the phase count.

// File: rtl/prls_pkg.sv
package prls_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_WAIT,
    ST_FETCH,
    ST_XFER,
    ST_PRESENT,
    ST_TURN,
    ST_SKIP
  } prls_state_e;

  localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

endpackage

// File: rtl/prls_decode.sv
module prls_decode #(
  parameter int          AW       = 32,
  parameter logic [31:0] BAR_BASE = 32'h4000_0000,
  parameter int          BAR_LOG2 = 12
) (
  input  logic [AW-1:0] addr,
  input  logic [3:0]    cmd,
  output logic          hit
);
  import prls_pkg::*;

  localparam int TAG_W = AW - BAR_LOG2;

  logic in_window;
  logic is_read;

  assign in_window = (addr[AW-1:BAR_LOG2] == BAR_BASE[AW-1:BAR_LOG2]);

  always_comb begin
    unique case (cmd)
      CMD_MEM_RD, CMD_MEM_RD_MULT, CMD_MEM_RD_LINE: is_read = 1'b1;
      default:                                      is_read = 1'b0;
    endcase
  end

  assign hit = in_window && is_read && (TAG_W > 0);

endmodule

// File: rtl/prls_lane.sv
module prls_lane #(
  parameter int DW = 32,
  localparam int LW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          odd_start,
  input  logic          capture,
  input  logic          advance,
  input  logic [LW-1:0] ldata,
  output logic          upper_sel,
  output logic [DW-1:0] ad_q
);

  logic          half_q;
  logic [DW-1:0] slice [2];

  for (genvar g = 0; g < 2; g++) begin : g_slice
    assign slice[g] = ldata[g*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      ad_q   <= '0;
    end else begin
      if (load)
        half_q <= odd_start;
      else if (advance)
        half_q <= ~half_q;
      if (capture)
        ad_q <= slice[half_q];
    end
  end

  assign upper_sel = half_q;

  // R6
  odd_start_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (upper_sel == $past(odd_start)));

  // R5
  alternate_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (upper_sel != $past(upper_sel)));

endmodule

// File: rtl/pci_rd_lane_seq.sv
module pci_rd_lane_seq #(
  parameter int          DW       = 32,
  parameter logic [31:0] BAR_BASE = 32'h4000_0000,
  parameter int          BAR_LOG2 = 12,
  localparam int         LW       = 2 * DW,
  localparam int         CW       = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic [CW-1:0] cbe_n,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          devsel_n,
  output logic          trdy_n,
  output logic          ctl_oe,
  output logic          bar_hit,
  output logic [DW-1:0] lcl_addr,
  input  logic          lcl_rdy_n,
  output logic          lo_xfer_n,
  output logic          hi_xfer_n,
  input  logic [LW-1:0] lcl_data
);
  import prls_pkg::*;

  prls_state_e   state;
  logic [DW-1:0] addr_q;
  logic [CW-1:0] cmd_q;
  logic          hit_w;
  logic          upper_sel;
  logic          phase_done;

  assign phase_done = (state == ST_PRESENT) && !irdy_n;

  prls_decode #(
    .AW       (DW),
    .BAR_BASE (BAR_BASE),
    .BAR_LOG2 (BAR_LOG2)
  ) u_decode (
    .addr (addr_q),
    .cmd  (cmd_q),
    .hit  (hit_w)
  );

  prls_lane #(
    .DW (DW)
  ) u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (state == ST_DECODE),
    .odd_start (addr_q[2]),
    .capture   (state == ST_XFER),
    .advance   (phase_done),
    .ldata     (lcl_data),
    .upper_sel (upper_sel),
    .ad_q      (ad_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      cmd_q    <= '0;
      bar_hit  <= 1'b0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      ctl_oe   <= 1'b0;
      ad_oe    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!frame_n) begin
            addr_q <= ad_in;
            cmd_q  <= cbe_n;
            state  <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (hit_w) begin
            bar_hit <= 1'b1;
            state   <= ST_WAIT;
          end else begin
            state   <= ST_SKIP;
          end
        end
        ST_WAIT: begin
          devsel_n <= 1'b0;
          ctl_oe   <= 1'b1;
          state    <= ST_FETCH;
        end
        ST_FETCH: begin
          if (!irdy_n && !lcl_rdy_n)
            state <= ST_XFER;
        end
        ST_XFER: begin
          trdy_n <= 1'b0;
          ad_oe  <= 1'b1;
          state  <= ST_PRESENT;
        end
        ST_PRESENT: begin
          if (!irdy_n) begin
            trdy_n <= 1'b1;
            if (frame_n) begin
              devsel_n <= 1'b1;
              ad_oe    <= 1'b0;
              state    <= ST_TURN;
            end else if (!lcl_rdy_n) begin
              state <= ST_XFER;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_TURN: begin
          ctl_oe  <= 1'b0;
          bar_hit <= 1'b0;
          state   <= ST_IDLE;
        end
        ST_SKIP: begin
          if (frame_n && irdy_n)
            state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign lcl_addr  = addr_q;
  assign lo_xfer_n = !((state == ST_XFER) && !upper_sel);
  assign hi_xfer_n = !((state == ST_XFER) &&  upper_sel);

  // R4
  devsel_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bar_hit) |=> (!devsel_n && ctl_oe));

  // R7
  strobe_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_xfer_n || !hi_xfer_n) |-> $past(!irdy_n && !lcl_rdy_n));

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~lo_xfer_n, ~hi_xfer_n}));

  // R7
  trdy_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_xfer_n || !hi_xfer_n) |=> !trdy_n);

  // R8
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_n) |=> (!ctl_oe && !bar_hit));

  // R2
  hit_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bar_hit) |-> $past(devsel_n && trdy_n));

  // R9
  ad_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> (ad_oe && bar_hit && !devsel_n));

  // R3
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (devsel_n && trdy_n && !ad_oe && !bar_hit));

endmodule

// File: tb/pci_rd_lane_seq_tb.sv
module pci_rd_lane_seq_tb_top;

  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, ctl_oe, bar_hit;
  logic [31:0] lcl_addr;
  logic        lcl_rdy_n = 1'b0;
  logic        lo_xfer_n, hi_xfer_n;
  logic [63:0] lcl_data;
  logic [28:0] qidx;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pci_rd_lane_seq #(.BAR_BASE(BASE), .BAR_LOG2(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .ctl_oe(ctl_oe), .bar_hit(bar_hit),
    .lcl_addr(lcl_addr), .lcl_rdy_n(lcl_rdy_n), .lo_xfer_n(lo_xfer_n),
    .hi_xfer_n(hi_xfer_n), .lcl_data(lcl_data)
  );

  function automatic logic [31:0] dword_of(input logic [29:0] k);
    return {2'b10, k} ^ 32'h1357_9BDF;
  endfunction

  // 64-bit memory back-end: holds its word until an upper strobe
  always_ff @(posedge clk) begin
    if (!bar_hit)
      qidx <= lcl_addr[31:3];
    else if (!hi_xfer_n)
      qidx <= qidx + 29'd1;
  end
  assign lcl_data = {dword_of({qidx, 1'b1}), dword_of({qidx, 1'b0})};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, input int n, input logic [3:0] cmd,
                         input bit stall, input bit exp_hit);
    int t = 0, done = 0, hit_t = -1, dev_t = -1, fin_t = -1, got = 0, strobes = 0;
    bit pending = 0, prev_strobe = 0, half_exp;
    string dreq;
    half_exp = a[2];
    dreq = a[2] ? "R6" : "R5";
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = a; cbe_n = cmd;
    @(negedge clk);
    ad_in = '0; cbe_n = 4'h0; irdy_n = 1'b0; frame_n = (n == 1);
    chk(lcl_addr == a, "R1 latched address", lcl_addr, a);
    chk(!ad_oe && !bar_hit, "R9 no drive after address phase", {30'd0, ad_oe, bar_hit}, 32'd0);
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      t++;
      if (pending) begin done++; pending = 0; end
      if (stall) lcl_rdy_n = (t % 3 == 1);
      if ((exp_hit && done == n) || (!exp_hit && t >= 10)) begin
        irdy_n = 1'b1; frame_n = 1'b1;
      end else if (exp_hit) begin
        frame_n = (done >= n - 1);
      end
      if (bar_hit && hit_t < 0) hit_t = t;
      if (!devsel_n && dev_t < 0) dev_t = t;
      if (hit_t > 0 && fin_t < 0)
        chk(bar_hit, "R2 hit held", {31'd0, bar_hit}, 32'd1);
      if (prev_strobe)
        chk(!trdy_n, "R7 trdy after strobe", {31'd0, trdy_n}, 32'd0);
      if (!lo_xfer_n || !hi_xfer_n) begin
        strobes++;
        chk(((!hi_xfer_n) == half_exp) && ((!lo_xfer_n) != half_exp), dreq,
            {30'd0, ~hi_xfer_n, ~lo_xfer_n}, {30'd0, half_exp, ~half_exp});
        half_exp = ~half_exp;
        prev_strobe = 1;
      end else begin
        prev_strobe = 0;
      end
      if (!trdy_n)
        chk(ad_oe, "R9 ad_oe with trdy", {31'd0, ad_oe}, 32'd1);
      if (!trdy_n && !irdy_n) begin
        chk(ad_out == dword_of(a[31:2] + 30'(got)), dreq, ad_out, dword_of(a[31:2] + 30'(got)));
        got++;
        pending = 1;
        if (got == n) fin_t = t;
      end
      if (fin_t > 0 && t == fin_t + 1)
        chk(devsel_n && trdy_n && !ad_oe && ctl_oe && bar_hit, "R8 release",
            {27'd0, devsel_n, trdy_n, ad_oe, ctl_oe, bar_hit}, 32'h1B);
      if (fin_t > 0 && t == fin_t + 2) begin
        chk(!bar_hit && !ctl_oe, "R8 idle", {30'd0, bar_hit, ctl_oe}, 32'd0);
        break;
      end
      if (!exp_hit) begin
        chk(!bar_hit && devsel_n && trdy_n && !ad_oe && !ctl_oe, "R3 ignored",
            {27'd0, bar_hit, devsel_n, trdy_n, ad_oe, ctl_oe}, 32'h0C);
        if (t >= 14) break;
      end
    end
    if (exp_hit) begin
      chk(hit_t == 1, "R2 hit timing", hit_t, 1);
      chk(dev_t == hit_t + 1, "R4 devsel timing", dev_t, hit_t + 1);
      chk(got == n, dreq, got, n);
      chk(strobes == n, "R7 strobe count", strobes, n);
      chk(fin_t > 0, "R8 completed", fin_t, 1);
    end
    lcl_rdy_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(devsel_n && trdy_n && lo_xfer_n && hi_xfer_n, "R10 reset high",
        {28'd0, devsel_n, trdy_n, lo_xfer_n, hi_xfer_n}, 32'hF);
    chk(!ad_oe && !ctl_oe && !bar_hit, "R10 reset low", {29'd0, ad_oe, ctl_oe, bar_hit}, 32'd0);
  endtask

  task automatic t_single_qword();  do_read(BASE + 32'h10, 1, 4'b0110, 0, 1); endtask
  task automatic t_single_dword();  do_read(BASE + 32'h14, 1, 4'b0110, 0, 1); endtask
  task automatic t_burst_qword();   do_read(BASE + 32'h20, 5, 4'b1100, 0, 1); endtask
  task automatic t_burst_dword();   do_read(BASE + 32'h2C, 4, 4'b1110, 0, 1); endtask
  task automatic t_stall_burst();   do_read(BASE + 32'h34, 6, 4'b0110, 1, 1); endtask
  task automatic t_stall_qword();   do_read(BASE + 32'h40, 3, 4'b0110, 1, 1); endtask
  task automatic t_miss_window();   do_read(32'h5000_0010, 2, 4'b0110, 0, 0); endtask
  task automatic t_write_ignored(); do_read(BASE + 32'h18, 2, 4'b0111, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_qword();
    t_single_dword();
    t_burst_qword();
    t_burst_dword();
    t_miss_window();
    t_stall_burst();
    t_write_ignored();
    t_stall_qword();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule